// File: doc/BRIEF.md
# Mailbox Command Transaction Engine

This block is the host-side sequencer for a two-way command mailbox. It accepts one command request at a time over a ready/valid interface, formats a 64-bit header word around the caller's command code and control flags, tags it with a sequence number and presents the header plus three data words to the command register bank in the same cycle as a doorbell strobe. It then services the inbound doorbell, which signals reset recovery, acknowledge, response, passthrough and timer-expiry events, and reports the outcome of every command as a one-cycle completion event that carries a status code and the status fields taken from the response.

At most one command is outstanding. The engine waits either for the acknowledge alone or also for a response, depending on a flag in the request. A per-command cycle timeout ends a silent exchange. A run of failed register writes stops further sends until the far side next raises any doorbell bit.

Top module: `mbx_engine`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `send_strobe` is 0, `db_clr` is 0, and `done_valid`, `pass_evt` and `tmr_evt` are 0.
- R2: On a send, `cmd_hdr` holds the request code in bits 15:0 and the sequence number in bits 31:16. Bits 47:32 hold the request flags OR'd with the acknowledge-required flag 0x0100, and bits 63:48 are zero. `cmd_w1`..`cmd_w3` hold the request data words.
- R3: The first accepted command gets sequence 1, and each later one gets the previous value plus 1. A value that would equal all ones in SEQ_W bits is replaced by 1, so 0 and all ones are never used.
- R4: `req_ready` is low from the cycle after a request is accepted until the cycle after its completion. Two completions never occur in consecutive cycles.
- R5: Each cycle in which `db_in` is nonzero is a service cycle. It serves exactly one kind of event, chosen in priority order reset (bit 0), acknowledge (bit 1), response (bit 2), passthrough (bit 3), timer (bit 4), unknown (bits 5 and up). `db_clr` pulses the served bit, or all unknown bits at once. No send happens in a service cycle.
- R6: Reset service pulses `db_clr` with all ones. An in-flight command returns to the not-sent state and is sent again with the same header once the doorbell is quiet.
- R7: On acknowledge of an in-flight command whose flags lack the response-required bit 0x0200, the command completes with code OK (0) and zero status fields. If the bit is set, the engine waits for a response instead. An acknowledge with nothing in flight is only cleared.
- R8: On response service with a command in flight, a match between `resp_hdr[31:16]` and the command sequence gives code OK with primary status `resp_hdr[63:48]` and secondary `resp_hdr[47:32]`. A mismatch gives code SEQ_ERR (1) with primary status 0x00F1. With nothing in flight, the bit is cleared and no completion occurs.
- R9: Passthrough service and timer service each produce a one-cycle `pass_evt` or `tmr_evt` pulse in the following cycle.
- R10: Unknown doorbell bits are cleared together and raise no event.
- R11: A command in flight with no service for TIMEOUT_CYCLES+1 cycles after its send cycle completes with code TIMEOUT (2), primary status 0x00FE. The engine returns to idle.
- R12: A send while `send_err` is high completes at once with code SEND_FAIL (3), primary status 0x00FE. After FAIL_LIMIT consecutive failures no send occurs until the next service cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine can take a request |
| req_cmd | input | 16 | Command class and subclass |
| req_flags | input | 16 | Control flags |
| req_w1 | input | 64 | Data word 1 |
| req_w2 | input | 64 | Data word 2 |
| req_w3 | input | 64 | Data word 3 |
| send_strobe | output | 1 | Load command registers and ring doorbell |
| send_err | input | 1 | Register write failed for this send |
| cmd_hdr | output | 64 | Header word |
| cmd_w1 | output | 64 | Command data word 1 |
| cmd_w2 | output | 64 | Command data word 2 |
| cmd_w3 | output | 64 | Command data word 3 |
| db_in | input | DB_W | Inbound doorbell bits |
| db_clr | output | DB_W | Doorbell clear mask |
| resp_hdr | input | 64 | Response header word |
| done_valid | output | 1 | Completion event |
| done_code | output | 2 | Completion code |
| done_pri | output | 16 | Primary status |
| done_sec | output | 16 | Secondary status |
| done_seq | output | 16 | Sequence of completed command |
| pass_evt | output | 1 | Passthrough event |
| tmr_evt | output | 1 | Timer-expiry event |

## Verification
`req_ready`, `send_strobe`, the command words and `db_clr` respond in the same cycle as the inputs that cause them. `done_*`, `pass_evt` and `tmr_evt` appear exactly one cycle after the service, send or timeout cycle that produces them. A timeout fires TIMEOUT_CYCLES+1 cycles after the send cycle, provided no service cycle intervenes. The bench's behavioural model predicts the combinational outputs from the inputs it drives in each cycle. It holds its predicted events for one cycle and compares every output at the falling edge, when both sides have settled.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W  = 64;
    localparam int FIELD_W = 16;

    // Control flag bits placed in header bits 47:32
    localparam logic [FIELD_W-1:0] CTRL_ACK_REQ = 16'h0100;
    localparam logic [FIELD_W-1:0] CTRL_RSP_REQ = 16'h0200;

    // Primary status values produced by the engine itself
    localparam logic [FIELD_W-1:0] STS_GENERIC = 16'h00FE;
    localparam logic [FIELD_W-1:0] STS_SEQ_BAD = 16'h00F1;

    // Doorbell bit positions, also the service priority order
    localparam int DB_RESET = 0;
    localparam int DB_ACK   = 1;
    localparam int DB_RSP   = 2;
    localparam int DB_PASS  = 3;
    localparam int DB_TMR   = 4;
    localparam int DB_KNOWN = 5;

    typedef enum logic [2:0] {
        SV_NONE, SV_RESET, SV_ACK, SV_RSP, SV_PASS, SV_TMR, SV_UNK
    } svc_t;

    typedef enum logic [1:0] {
        DN_OK, DN_SEQERR, DN_TIMEOUT, DN_SENDFAIL
    } done_t;

    typedef enum logic [1:0] {
        MB_IDLE, MB_SENT, MB_WRESP
    } mb_t;

    typedef struct packed {
        logic [FIELD_W-1:0] flags;
        logic [FIELD_W-1:0] seq;
        logic [FIELD_W-1:0] code;
    } cmd_hdr_t;

    function automatic logic [WORD_W-1:0] pack_hdr(input cmd_hdr_t h);
        return {{FIELD_W{1'b0}}, h.flags, h.seq, h.code};
    endfunction

endpackage

// File: rtl/mbx_seq_gen.sv
module mbx_seq_gen #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [SEQ_W-1:0] seq
);
    localparam logic [SEQ_W-1:0] SEQ_FIRST = SEQ_W'(1);
    localparam logic [SEQ_W-1:0] SEQ_TOP   = '1;

    logic [SEQ_W-1:0] seq_inc;

    always_comb begin
        seq_inc = seq + SEQ_FIRST;
        if (seq_inc == SEQ_TOP) seq_inc = SEQ_FIRST;
    end

    always_ff @(posedge clk) begin
        if (rst)      seq <= SEQ_FIRST;
        else if (adv) seq <= seq_inc;
    end
endmodule

// File: rtl/mbx_db_arbiter.sv
module mbx_db_arbiter
    import mbx_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic [DB_W-1:0] db,
    output svc_t            sel,
    output logic [DB_W-1:0] clr
);
    logic [DB_W-1:0] unk;

    generate
        for (genvar i = 0; i < DB_W; i++) begin : g_unk
            if (i >= DB_KNOWN) begin : g_hi
                assign unk[i] = db[i];
            end else begin : g_lo
                assign unk[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        sel = SV_NONE;
        clr = '0;
        if (db[DB_RESET]) begin
            sel = SV_RESET;
            clr = '1;
        end else if (db[DB_ACK]) begin
            sel = SV_ACK;
            clr = DB_W'(1) << DB_ACK;
        end else if (db[DB_RSP]) begin
            sel = SV_RSP;
            clr = DB_W'(1) << DB_RSP;
        end else if (db[DB_PASS]) begin
            sel = SV_PASS;
            clr = DB_W'(1) << DB_PASS;
        end else if (db[DB_TMR]) begin
            sel = SV_TMR;
            clr = DB_W'(1) << DB_TMR;
        end else if (|unk) begin
            sel = SV_UNK;
            clr = unk;
        end
    end
endmodule

// File: rtl/mbx_timeout.sv
module mbx_timeout #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= CNT_W'(CYCLES);
        else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int SEQ_W          = 16,
    parameter int DB_W           = 8,
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int FAIL_LIMIT     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [15:0]     req_cmd,
    input  logic [15:0]     req_flags,
    input  logic [63:0]     req_w1,
    input  logic [63:0]     req_w2,
    input  logic [63:0]     req_w3,
    output logic            send_strobe,
    input  logic            send_err,
    output logic [63:0]     cmd_hdr,
    output logic [63:0]     cmd_w1,
    output logic [63:0]     cmd_w2,
    output logic [63:0]     cmd_w3,
    input  logic [DB_W-1:0] db_in,
    output logic [DB_W-1:0] db_clr,
    input  logic [63:0]     resp_hdr,
    output logic            done_valid,
    output logic [1:0]      done_code,
    output logic [15:0]     done_pri,
    output logic [15:0]     done_sec,
    output logic [15:0]     done_seq,
    output logic            pass_evt,
    output logic            tmr_evt
);
    localparam int FW = $clog2(FAIL_LIMIT + 1);

    logic [SEQ_W-1:0] seq_cur;
    logic             accept;
    logic             svc;
    svc_t             sel;
    logic             expired;
    logic             load_tmo;
    logic             tmo_hit;

    logic             held;
    mb_t              st;
    cmd_hdr_t         hdr_q;
    logic [63:0]      w1_q, w2_q, w3_q;
    logic             halt;
    logic [FW-1:0]    fails;

    mbx_seq_gen #(.SEQ_W(SEQ_W)) u_seq (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .seq (seq_cur)
    );

    mbx_db_arbiter #(.DB_W(DB_W)) u_arb (
        .db  (db_in),
        .sel (sel),
        .clr (db_clr)
    );

    mbx_timeout #(.CYCLES(TIMEOUT_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .load    (load_tmo),
        .expired (expired)
    );

    assign svc         = |db_in;
    assign req_ready   = !held;
    assign accept      = req_valid && req_ready;
    assign send_strobe = held && (st == MB_IDLE) && !halt && !svc;
    assign load_tmo    = send_strobe && !send_err;
    assign tmo_hit     = (st != MB_IDLE) && !svc && expired;

    assign cmd_hdr = pack_hdr(hdr_q);
    assign cmd_w1  = w1_q;
    assign cmd_w2  = w2_q;
    assign cmd_w3  = w3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= 1'b0;
            st         <= MB_IDLE;
            hdr_q      <= '0;
            w1_q       <= '0;
            w2_q       <= '0;
            w3_q       <= '0;
            halt       <= 1'b0;
            fails      <= '0;
            done_valid <= 1'b0;
            done_code  <= DN_OK;
            done_pri   <= '0;
            done_sec   <= '0;
            done_seq   <= '0;
            pass_evt   <= 1'b0;
            tmr_evt    <= 1'b0;
        end else begin
            done_valid <= 1'b0;
            pass_evt   <= 1'b0;
            tmr_evt    <= 1'b0;

            if (accept) begin
                held        <= 1'b1;
                hdr_q.code  <= req_cmd;
                hdr_q.flags <= req_flags | CTRL_ACK_REQ;
                hdr_q.seq   <= 16'(seq_cur);
                w1_q        <= req_w1;
                w2_q        <= req_w2;
                w3_q        <= req_w3;
            end

            if (svc) begin
                fails <= '0;
                halt  <= 1'b0;
                unique case (sel)
                    SV_RESET: st <= MB_IDLE;
                    SV_ACK: begin
                        if (st == MB_SENT) begin
                            if ((hdr_q.flags & CTRL_RSP_REQ) != '0) begin
                                st <= MB_WRESP;
                            end else begin
                                st         <= MB_IDLE;
                                held       <= 1'b0;
                                done_valid <= 1'b1;
                                done_code  <= DN_OK;
                                done_pri   <= '0;
                                done_sec   <= '0;
                                done_seq   <= hdr_q.seq;
                            end
                        end
                    end
                    SV_RSP: begin
                        if (st != MB_IDLE) begin
                            st         <= MB_IDLE;
                            held       <= 1'b0;
                            done_valid <= 1'b1;
                            done_seq   <= hdr_q.seq;
                            done_sec   <= resp_hdr[47:32];
                            if (resp_hdr[31:16] == hdr_q.seq) begin
                                done_code <= DN_OK;
                                done_pri  <= resp_hdr[63:48];
                            end else begin
                                done_code <= DN_SEQERR;
                                done_pri  <= STS_SEQ_BAD;
                            end
                        end
                    end
                    SV_PASS: pass_evt <= 1'b1;
                    SV_TMR:  tmr_evt  <= 1'b1;
                    default: ;
                endcase
            end else if (send_strobe) begin
                if (send_err) begin
                    held       <= 1'b0;
                    done_valid <= 1'b1;
                    done_code  <= DN_SENDFAIL;
                    done_pri   <= STS_GENERIC;
                    done_sec   <= '0;
                    done_seq   <= hdr_q.seq;
                    fails      <= fails + FW'(1);
                    if (fails == FW'(FAIL_LIMIT - 1)) halt <= 1'b1;
                end else begin
                    st    <= MB_SENT;
                    fails <= '0;
                end
            end else if (tmo_hit) begin
                st         <= MB_IDLE;
                held       <= 1'b0;
                done_valid <= 1'b1;
                done_code  <= DN_TIMEOUT;
                done_pri   <= STS_GENERIC;
                done_sec   <= '0;
                done_seq   <= hdr_q.seq;
            end
        end
    end
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk
    import mbx_pkg::*;
#(
    parameter int DB_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            send_strobe,
    input logic [63:0]     cmd_hdr,
    input logic [DB_W-1:0] db_in,
    input logic [DB_W-1:0] db_clr,
    input logic            done_valid
);
    AST_CLR_WITHIN_BELL: assert property (@(posedge clk) disable iff (rst)
        !db_in[DB_RESET] |-> ((db_clr & ~db_in) == '0)); // R5
    AST_CLR_ONE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        (!db_in[DB_RESET] && (db_in[DB_KNOWN-1:0] != '0)) |-> ($countones(db_clr) == 1)); // R5
    AST_QUIET_CLR: assert property (@(posedge clk) disable iff (rst)
        (db_in == '0) |-> (db_clr == '0)); // R5
    AST_SEND_QUIET_BELL: assert property (@(posedge clk) disable iff (rst)
        send_strobe |-> (db_in == '0)); // R5
    AST_RESET_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
        db_in[DB_RESET] |-> (&db_clr)); // R6
    AST_ACK_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        send_strobe |-> ((cmd_hdr[47:32] & CTRL_ACK_REQ) != '0)); // R2
    AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (rst)
        send_strobe |-> (cmd_hdr[31:16] != '0)); // R3
    AST_BUSY_ON_SEND: assert property (@(posedge clk) disable iff (rst)
        send_strobe |-> !req_ready); // R4
    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid); // R4
endmodule

bind mbx_engine mbx_engine_chk #(.DB_W(DB_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .send_strobe (send_strobe),
    .cmd_hdr     (cmd_hdr),
    .db_in       (db_in),
    .db_clr      (db_clr),
    .done_valid  (done_valid)
);

// File: tb/mbx_engine_tb.sv
module mbx_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_W      = 3;
    localparam int DB_W       = 8;
    localparam int TMO        = 20;
    localparam int FLIM       = 4;
    localparam logic [15:0] ACKF = 16'h0100;
    localparam logic [15:0] RSPF = 16'h0200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [15:0] req_cmd = '0, req_flags = '0;
    logic [63:0] req_w1 = '0, req_w2 = '0, req_w3 = '0;
    logic send_strobe;
    logic send_err = 1'b0;
    logic [63:0] cmd_hdr, cmd_w1, cmd_w2, cmd_w3;
    logic [DB_W-1:0] db_reg = '0;
    logic [DB_W-1:0] db_clr;
    logic [63:0] resp_hdr = '0;
    logic done_valid;
    logic [1:0] done_code;
    logic [15:0] done_pri, done_sec, done_seq;
    logic pass_evt, tmr_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_engine #(.SEQ_W(SEQ_W), .DB_W(DB_W), .TIMEOUT_CYCLES(TMO), .FAIL_LIMIT(FLIM)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_flags(req_flags), .req_w1(req_w1), .req_w2(req_w2),
        .req_w3(req_w3), .send_strobe(send_strobe), .send_err(send_err),
        .cmd_hdr(cmd_hdr), .cmd_w1(cmd_w1), .cmd_w2(cmd_w2), .cmd_w3(cmd_w3),
        .db_in(db_reg), .db_clr(db_clr), .resp_hdr(resp_hdr),
        .done_valid(done_valid), .done_code(done_code), .done_pri(done_pri),
        .done_sec(done_sec), .done_seq(done_seq), .pass_evt(pass_evt), .tmr_evt(tmr_evt)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    bit m_held;
    int m_st;
    int m_timer;
    int m_fails;
    bit m_halt;
    int m_seqnext;
    logic [15:0] m_cmd, m_flags, m_seq;
    logic [63:0] m_w1, m_w2, m_w3;
    bit e_dv, e_pt, e_tm;
    logic [1:0] e_code;
    logic [15:0] e_pri, e_sec, e_seq;
    logic [DB_W-1:0] e_clr = '0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic complete(input logic [1:0] c, input logic [15:0] p, input logic [15:0] s);
        e_dv = 1; e_code = c; e_pri = p; e_sec = s; e_seq = m_seq;
        m_held = 0; m_st = 0;
    endtask

    always @(posedge clk) if (!rst) db_reg <= db_reg & ~e_clr;

    always @(negedge clk) begin
        if (rst) begin
            m_held = 0; m_st = 0; m_timer = 0; m_fails = 0; m_halt = 0; m_seqnext = 1;
            m_cmd = '0; m_flags = '0; m_seq = '0; m_w1 = '0; m_w2 = '0; m_w3 = '0;
            e_dv = 0; e_pt = 0; e_tm = 0; e_code = '0; e_pri = '0; e_sec = '0; e_seq = '0;
            e_clr = '0;
        end else begin
            logic [DB_W-1:0] db;
            bit svc, e_send, acc, tmo;
            // registered events from the previous cycle
            chk(done_valid == e_dv, "done_valid", 64'(done_valid), 64'(e_dv));
            if (e_dv) begin
                chk(done_code == e_code, "done_code", 64'(done_code), 64'(e_code));
                chk(done_pri == e_pri, "done_pri", 64'(done_pri), 64'(e_pri));
                chk(done_sec == e_sec, "done_sec", 64'(done_sec), 64'(e_sec));
                chk(done_seq == e_seq, "done_seq", 64'(done_seq), 64'(e_seq));
            end
            chk(pass_evt == e_pt, "pass_evt", 64'(pass_evt), 64'(e_pt));
            chk(tmr_evt == e_tm, "tmr_evt", 64'(tmr_evt), 64'(e_tm));
            // same-cycle outputs
            db = db_reg;
            svc = (db != '0);
            e_send = m_held && m_st == 0 && !m_halt && !svc;
            chk(req_ready == !m_held, "req_ready", 64'(req_ready), 64'(!m_held));
            chk(send_strobe == e_send, "send_strobe", 64'(send_strobe), 64'(e_send));
            if (e_send) begin
                chk(cmd_hdr == {16'h0, m_flags | ACKF, m_seq, m_cmd}, "cmd_hdr", cmd_hdr,
                    {16'h0, m_flags | ACKF, m_seq, m_cmd});
                chk(cmd_w1 == m_w1 && cmd_w2 == m_w2 && cmd_w3 == m_w3, "cmd_words", cmd_w3, m_w3);
            end
            if (db[0])      e_clr = '1;
            else if (db[1]) e_clr = 8'h02;
            else if (db[2]) e_clr = 8'h04;
            else if (db[3]) e_clr = 8'h08;
            else if (db[4]) e_clr = 8'h10;
            else            e_clr = db & 8'hE0;
            chk(db_clr == e_clr, "db_clr", 64'(db_clr), 64'(e_clr));
            // next state
            e_dv = 0; e_pt = 0; e_tm = 0;
            acc = req_valid && !m_held;
            tmo = (m_st != 0) && !svc && (m_timer == 0);
            if (svc) begin
                m_fails = 0; m_halt = 0;
                if (db[0]) m_st = 0;
                else if (db[1]) begin
                    if (m_st == 1) begin
                        if ((m_flags & RSPF) != 0) m_st = 2;
                        else complete(2'd0, 16'h0, 16'h0);
                    end
                end else if (db[2]) begin
                    if (m_st != 0) begin
                        if (resp_hdr[31:16] == m_seq) complete(2'd0, resp_hdr[63:48], resp_hdr[47:32]);
                        else complete(2'd1, 16'h00F1, resp_hdr[47:32]);
                    end
                end else if (db[3]) e_pt = 1;
                else if (db[4]) e_tm = 1;
            end else if (e_send) begin
                if (send_err) begin
                    complete(2'd3, 16'h00FE, 16'h0);
                    m_fails++;
                    if (m_fails == FLIM) m_halt = 1;
                end else begin
                    m_st = 1; m_fails = 0;
                end
            end else if (tmo) begin
                complete(2'd2, 16'h00FE, 16'h0);
            end
            if (e_send && !send_err) m_timer = TMO;
            else if (m_timer > 0) m_timer--;
            if (acc) begin
                m_held = 1; m_cmd = req_cmd; m_flags = req_flags; m_seq = 16'(m_seqnext);
                m_w1 = req_w1; m_w2 = req_w2; m_w3 = req_w3;
                m_seqnext++;
                if (m_seqnext == (1 << SEQ_W) - 1) m_seqnext = 1;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic ring(input logic [DB_W-1:0] b);
        @(posedge clk); #1;
        db_reg = db_reg | b;
    endtask

    task automatic issue(input logic [15:0] code, input logic [15:0] fl, input logic [63:0] w);
        @(posedge clk); #1;
        req_valid = 1; req_cmd = code; req_flags = fl;
        req_w1 = w; req_w2 = ~w; req_w3 = w ^ 64'h5555_0000_AAAA_0001;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    function automatic logic [63:0] mkresp(input logic [15:0] p, input logic [15:0] s, input logic [15:0] q);
        return {p, s, q, 16'h0};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired (R1) actual=running expected=finished");
        summary();
    end

    initial begin
        idle(3);
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        tag = "R1";
        chk(req_ready == 1 && send_strobe == 0 && db_clr == 0 && done_valid == 0,
            "reset outputs", {req_ready, send_strobe, done_valid}, 3'b100);
        // R7 acknowledge-only command, R2 header
        tag = "R7";
        issue(16'h0A03, 16'h0011, 64'h1111_2222_3333_4444);
        idle(2); ring(8'h02); idle(3);
        // R7 stray acknowledge
        ring(8'h02); idle(2);
        // R8 matched response
        tag = "R8";
        issue(16'h0B01, RSPF, 64'hDEAD_BEEF_0000_0001);
        idle(2); ring(8'h02); idle(2);
        resp_hdr = mkresp(16'h1234, 16'h5678, m_seq);
        ring(8'h04); idle(3);
        // R8 mismatched response
        issue(16'h0B02, RSPF, 64'h7);
        idle(2); ring(8'h02); idle(2);
        resp_hdr = mkresp(16'h0000, 16'h9ABC, m_seq ^ 16'h0001);
        ring(8'h04); idle(3);
        // R8 response with nothing pending
        ring(8'h04); idle(3);
        // R5 R9 R10 priority among simultaneous bits
        tag = "R5";
        issue(16'h0C00, RSPF, 64'h42);
        idle(2); ring(8'hE0 | 8'h18 | 8'h02); idle(6);
        tag = "R9";
        ring(8'h10); idle(2); ring(8'h08); idle(2);
        tag = "R10";
        ring(8'hA0); idle(2);
        tag = "R8";
        resp_hdr = mkresp(16'h0001, 16'h0002, m_seq);
        ring(8'h04); idle(3);
        // R6 reset recovery and resend
        tag = "R6";
        issue(16'h0D05, 16'h0000, 64'h99);
        idle(3); ring(8'h01 | 8'h02 | 8'h40); idle(3);
        ring(8'h02); idle(3);
        // R11 timeout while waiting for response
        tag = "R11";
        issue(16'h0E00, RSPF, 64'h5);
        idle(3); ring(8'h02); idle(TMO + 6);
        // R12 repeated send failures and halt
        tag = "R12";
        send_err = 1;
        for (int i = 0; i < FLIM; i++) begin
            issue(16'h0F00 + 16'(i), 16'h0, 64'(i));
            idle(2);
        end
        issue(16'h0F10, 16'h0, 64'h10);
        idle(5);
        send_err = 0;
        idle(3);
        ring(8'h08); idle(3); ring(8'h02); idle(3);
        // R3 sequence wrap over several commands
        tag = "R3";
        for (int i = 0; i < 9; i++) begin
            issue(16'h1000 + 16'(i), 16'h0, 64'(i * 3));
            idle(2); ring(8'h02); idle(2);
        end
        tag = "R4";
        issue(16'h2000, RSPF, 64'h1);
        idle(4); ring(8'h02); idle(2);
        resp_hdr = mkresp(16'h0, 16'h0, m_seq);
        ring(8'h04); idle(4);
        summary();
    end
endmodule